// File: doc/BRIEF.md
# Pipe Buffer Ready Logic

This block follows one pipe's packet buffer inside a USB controller and decides when the buffer is ready. In the receive direction, ready means software may read the stored data. In the transmit direction, ready means the stored data may be sent. The rule applied depends on three configuration bits: transfer direction, continuous mode, and auto-NAK on short packets. A single-packet rule applies when continuous mode is off. A buffer-fill rule, with special handling of zero-length packets, applies when it is on.

Received packets arrive as one-cycle events that carry a byte count and short / zero-length flags. Software fills a transmit buffer one byte per write strobe and may commit a partial buffer with a buffer-valid strobe. The block outputs a ready flag and the stored byte count. When a reception transfer ends and auto-NAK is enabled, it also raises a one-cycle request that forces the pipe response to NAK. A clear input empties the buffer once software has consumed it.

Top module: `pipe_buf_ready`

## Requirements
- R1: The configuration register reads back continuous mode at bit 8, short-packet auto-NAK at bit 7 and direction at bit 4 (0 = receive, 1 = transmit). Every other bit reads as 0, whatever value was written.
- R2: When `host_role_i` is 0 during a configuration write, the direction bit is stored as 0 (receive).
- R3: With continuous mode off and direction receive, any received packet sets ready in the following cycle. This includes a zero-length packet. The count then equals the packet length.
- R4: With continuous mode off and direction transmit, ready rises in the cycle after the write that brings the count up to `mps_i`. A buffer-valid strobe also sets ready at any count, including 0.
- R5: With continuous mode on and direction receive, packet lengths accumulate. The count saturates at 256, and ready rises when the accumulated count reaches 256.
- R6: With continuous mode on and direction receive, a short packet with a non-zero length sets ready.
- R7: With continuous mode on and direction receive, a zero-length packet sets ready only if the count is non-zero. At an empty buffer it is dropped: the count stays 0, and neither ready nor the NAK request is raised.
- R8: With continuous mode on and direction transmit, ready rises when the 256th byte is written. A buffer-valid strobe also sets ready at any smaller count, including 0.
- R9: The NAK request is a one-cycle pulse. It coincides with ready rising on a reception that ends the transfer (a short or zero-length packet), and it occurs only when the auto-NAK bit is 1. It never occurs when the bit is 0.
- R10: A clear gives a count of 0, ready 0 and NAK request 0 in the next cycle. It takes priority over a packet event or write in the same cycle.
- R11: While ready is 1, further packets, writes and buffer-valid strobes leave the count and ready unchanged.
- R12: After reset, ready, count, NAK request and the configuration register are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_role_i | input | 1 | 1 when the controller acts as host |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration register read value |
| mps_i | input | 9 | Maximum packet size in bytes |
| rx_pkt_i | input | 1 | One-cycle received-packet event |
| rx_len_i | input | 9 | Byte count of the received packet |
| rx_short_i | input | 1 | Received packet is shorter than maximum size |
| rx_zlp_i | input | 1 | Received packet has zero length |
| sw_wr_i | input | 1 | Software writes one byte into the buffer |
| sw_bval_i | input | 1 | Software commits the buffer as valid |
| clr_i | input | 1 | Empty the buffer |
| ready_o | output | 1 | Buffer readable (receive) or sendable (transmit) |
| count_o | output | 9 | Bytes held in the buffer |
| nak_req_o | output | 1 | One-cycle request to force the pipe response to NAK |

## Verification
A clear and a buffer update can land in the same cycle: a packet event in the receive direction, or a byte write in the transmit direction. The bench provokes this by asserting `clr_i` together with `rx_pkt_i` while the buffer holds data, and again together with `sw_wr_i`. It judges the result at the next sample point, where count, ready and the NAK request must all be 0. The bench sweeps packet lengths, maximum packet sizes and both auto-NAK settings in each mode. It compares every result against counts computed arithmetically from the requirements.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned CONT_BIT  = 8;
  localparam int unsigned SNAK_BIT  = 7;
  localparam int unsigned DIR_BIT   = 4;
  localparam logic        DIR_RX    = 1'b0;
  localparam logic        DIR_TX    = 1'b1;

  typedef struct packed {
    logic cont;
    logic snak;
    logic dir;
  } pbr_cfg_t;
endpackage

// File: rtl/pbr_cfg_reg.sv
module pbr_cfg_reg
  import pbr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             host_role_i,
  output pbr_cfg_t         cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  pbr_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.cont <= wdata_i[CONT_BIT];
      cfg_q.snak <= wdata_i[SNAK_BIT];
      // peripheral role: only receive direction allowed
      cfg_q.dir  <= host_role_i & wdata_i[DIR_BIT];
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[CONT_BIT] = cfg_q.cont;
    rdata_o[SNAK_BIT] = cfg_q.snak;
    rdata_o[DIR_BIT]  = cfg_q.dir;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pbr_rx_eval.sv
module pbr_rx_eval #(
  parameter int unsigned SIDE_BYTES = 256,
  parameter int unsigned CNT_W      = $clog2(SIDE_BYTES) + 1
) (
  input  logic             cont_i,
  input  logic             snak_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             short_i,
  input  logic             zlp_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             set_ready_o,
  output logic             nak_o
);
  localparam logic [CNT_W-1:0] SIDE_V = CNT_W'(SIDE_BYTES);

  logic [CNT_W:0] sum;
  logic           zero_pkt;
  logic           full;
  logic           drop;
  logic           xfer_end;

  assign sum      = {1'b0, cnt_i} + {1'b0, len_i};
  assign full     = sum >= {1'b0, SIDE_V};
  assign zero_pkt = zlp_i | (len_i == '0);

  always_comb begin
    cnt_nxt_o = full ? SIDE_V : sum[CNT_W-1:0];
    if (!cont_i) begin
      drop        = 1'b0;
      set_ready_o = 1'b1;
    end else begin
      // empty buffer swallows a zero-length packet
      drop        = zero_pkt && (cnt_i == '0);
      set_ready_o = !drop && (full || (short_i && !zero_pkt) || zero_pkt);
    end
    xfer_end = !drop && (short_i || zero_pkt);
    nak_o    = snak_i && xfer_end;
  end
endmodule

// File: rtl/pbr_tx_eval.sv
module pbr_tx_eval #(
  parameter int unsigned SIDE_BYTES = 256,
  parameter int unsigned CNT_W      = $clog2(SIDE_BYTES) + 1
) (
  input  logic             cont_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mps_i,
  input  logic             wr_i,
  input  logic             bval_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             set_ready_o
);
  localparam logic [CNT_W-1:0] SIDE_V = CNT_W'(SIDE_BYTES);

  logic             inc;
  logic [CNT_W-1:0] limit;

  assign inc       = wr_i && (cnt_i < SIDE_V);
  assign cnt_nxt_o = cnt_i + CNT_W'(inc);

  always_comb begin
    if (cont_i)               limit = SIDE_V;
    else if (mps_i > SIDE_V)  limit = SIDE_V;
    else                      limit = mps_i;
    set_ready_o = bval_i || (wr_i && (limit != '0) && (cnt_nxt_o >= limit));
  end
endmodule

// File: rtl/pipe_buf_ready.sv
module pipe_buf_ready
  import pbr_pkg::*;
#(
  parameter  int unsigned SIDE_BYTES = 256,
  localparam int unsigned CNT_W      = $clog2(SIDE_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_role_i,
  input  logic             cfg_we_i,
  input  logic [15:0]      cfg_wdata_i,
  output logic [15:0]      cfg_rdata_o,
  input  logic [CNT_W-1:0] mps_i,
  input  logic             rx_pkt_i,
  input  logic [CNT_W-1:0] rx_len_i,
  input  logic             rx_short_i,
  input  logic             rx_zlp_i,
  input  logic             sw_wr_i,
  input  logic             sw_bval_i,
  input  logic             clr_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] count_o,
  output logic             nak_req_o
);
  pbr_cfg_t         cfg;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic             nak_q;
  logic [CNT_W-1:0] rx_cnt_nxt;
  logic             rx_set;
  logic             rx_nak;
  logic [CNT_W-1:0] tx_cnt_nxt;
  logic             tx_set;
  logic             rx_ev;
  logic             tx_ev;

  pbr_cfg_reg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .host_role_i (host_role_i),
    .cfg_o       (cfg),
    .rdata_o     (cfg_rdata_o)
  );

  pbr_rx_eval #(.SIDE_BYTES(SIDE_BYTES), .CNT_W(CNT_W)) u_rx (
    .cont_i      (cfg.cont),
    .snak_i      (cfg.snak),
    .cnt_i       (cnt_q),
    .len_i       (rx_len_i),
    .short_i     (rx_short_i),
    .zlp_i       (rx_zlp_i),
    .cnt_nxt_o   (rx_cnt_nxt),
    .set_ready_o (rx_set),
    .nak_o       (rx_nak)
  );

  pbr_tx_eval #(.SIDE_BYTES(SIDE_BYTES), .CNT_W(CNT_W)) u_tx (
    .cont_i      (cfg.cont),
    .cnt_i       (cnt_q),
    .mps_i       (mps_i),
    .wr_i        (sw_wr_i),
    .bval_i      (sw_bval_i),
    .cnt_nxt_o   (tx_cnt_nxt),
    .set_ready_o (tx_set)
  );

  assign rx_ev = !ready_q && (cfg.dir == DIR_RX) && rx_pkt_i;
  assign tx_ev = !ready_q && (cfg.dir == DIR_TX) && (sw_wr_i || sw_bval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      if (clr_i) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else if (rx_ev) begin
        cnt_q   <= rx_cnt_nxt;
        ready_q <= rx_set;
        nak_q   <= rx_nak;
      end else if (tx_ev) begin
        cnt_q   <= tx_cnt_nxt;
        ready_q <= tx_set;
      end
    end
  end

  assign ready_o   = ready_q;
  assign count_o   = cnt_q;
  assign nak_req_o = nak_q;
endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
  parameter int unsigned SIDE_BYTES = 256,
  parameter int unsigned CNT_W      = $clog2(SIDE_BYTES) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_role_i,
  input logic             cfg_we_i,
  input logic             clr_i,
  input logic [15:0]      cfg_rdata_o,
  input logic             ready_o,
  input logic [CNT_W-1:0] count_o,
  input logic             nak_req_o
);
  // R1
  unused_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~16'h0190) == 16'h0000);

  // R2
  dir_host_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_rdata_o[4]) |-> $past(cfg_we_i && host_role_i));

  // R5
  count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(SIDE_BYTES));

  // R9
  nak_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_req_o |-> ready_o);

  // R9
  nak_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_req_o |=> !nak_req_o);

  // R10
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ready_o && count_o == '0 && !nak_req_o));

  // R11
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !clr_i) |=> (ready_o && $stable(count_o)));
endmodule

bind pipe_buf_ready pbr_chk #(.SIDE_BYTES(SIDE_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_role_i (host_role_i),
  .cfg_we_i    (cfg_we_i),
  .clr_i       (clr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .ready_o     (ready_o),
  .count_o     (count_o),
  .nak_req_o   (nak_req_o)
);

// File: tb/tb_pipe_buf_ready.sv
`timescale 1ns/1ps
module tb_pipe_buf_ready;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_role_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic [8:0]  mps_i = 9'd64;
  logic        rx_pkt_i = 1'b0;
  logic [8:0]  rx_len_i = '0;
  logic        rx_short_i = 1'b0;
  logic        rx_zlp_i = 1'b0;
  logic        sw_wr_i = 1'b0;
  logic        sw_bval_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        ready_o;
  logic [8:0]  count_o;
  logic        nak_req_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  pipe_buf_ready dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_role_i(host_role_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .mps_i(mps_i), .rx_pkt_i(rx_pkt_i), .rx_len_i(rx_len_i),
    .rx_short_i(rx_short_i), .rx_zlp_i(rx_zlp_i), .sw_wr_i(sw_wr_i),
    .sw_bval_i(sw_bval_i), .clr_i(clr_i), .ready_o(ready_o),
    .count_o(count_o), .nak_req_o(nak_req_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int rdy, input int cnt, input int nak);
    chk({req, " ready"}, int'(ready_o), rdy);
    chk({req, " count"}, int'(count_o), cnt);
    chk({req, " nak"}, int'(nak_req_o), nak);
  endtask

  task automatic cfg(input bit cont, input bit snak, input bit dir);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = '0;
    cfg_wdata_i[8] = cont;
    cfg_wdata_i[7] = snak;
    cfg_wdata_i[4] = dir;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  task automatic rx(input int len, input bit sh, input bit z);
    @(negedge clk_i);
    rx_pkt_i = 1'b1;
    rx_len_i = 9'(len);
    rx_short_i = sh;
    rx_zlp_i = z;
    @(negedge clk_i);
    rx_pkt_i = 1'b0;
    rx_short_i = 1'b0;
    rx_zlp_i = 1'b0;
  endtask

  task automatic wr(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sw_wr_i = 1'b1;
    end
    @(negedge clk_i);
    sw_wr_i = 1'b0;
  endtask

  task automatic bval();
    @(negedge clk_i);
    sw_bval_i = 1'b1;
    @(negedge clk_i);
    sw_bval_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lens[6] = '{0, 1, 7, 63, 64, 255};
    int steps[3] = '{64, 100, 200};
    int mpss[3] = '{1, 8, 64};
    int exp;
    #12;
    // R12 reset state
    chk_state("R12", 0, 0, 0);
    chk("R12 cfg", int'(cfg_rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 layout, R2 role gating
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 16'hFFFF;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R1 host all-ones", int'(cfg_rdata_o), 32'h0190);
    host_role_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 16'hFFFF;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R2 peripheral dir", int'(cfg_rdata_o), 32'h0180);
    host_role_i = 1'b1;

    // R3 / R9 / R11 single-packet receive
    for (int s = 0; s < 2; s++) begin
      cfg(1'b0, s[0], 1'b0);
      foreach (lens[k]) begin
        clear();
        rx(lens[k], lens[k] < 64, lens[k] == 0);
        chk_state("R3 R9 rx single", 1, lens[k], (s == 1 && lens[k] < 64) ? 1 : 0);
        @(negedge clk_i);
        chk("R9 nak pulse ends", int'(nak_req_o), 0);
        rx(10, 1'b1, 1'b0);
        chk_state("R11 rx ignored", 1, lens[k], 0);
      end
    end

    // R10 clear vs packet in same cycle
    cfg(1'b1, 1'b1, 1'b0);
    clear();
    rx(40, 1'b0, 1'b0);
    @(negedge clk_i);
    clr_i = 1'b1; rx_pkt_i = 1'b1; rx_len_i = 9'd20; rx_short_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; rx_pkt_i = 1'b0; rx_short_i = 1'b0;
    chk_state("R10 clear beats rx", 0, 0, 0);

    // R5 accumulation to 256
    foreach (steps[k]) begin
      clear();
      exp = 0;
      for (int p = 0; p < 8 && exp < 256; p++) begin
        rx(steps[k], 1'b0, 1'b0);
        exp = (exp + steps[k] > 256) ? 256 : exp + steps[k];
        chk_state("R5 accumulate", exp >= 256 ? 1 : 0, exp, 0);
      end
    end

    // R6 / R7 / R9 in continuous receive, both auto-NAK settings
    for (int s = 0; s < 2; s++) begin
      cfg(1'b1, s[0], 1'b0);
      clear();
      rx(64, 1'b0, 1'b0);
      rx(10, 1'b1, 1'b0);
      chk_state("R6 R9 short nonzero", 1, 74, s);
      clear();
      rx(0, 1'b1, 1'b1);
      chk_state("R7 zlp empty dropped", 0, 0, 0);
      rx(30, 1'b0, 1'b0);
      chk_state("R7 data pending", 0, 30, 0);
      rx(0, 1'b1, 1'b1);
      chk_state("R7 R9 zlp after data", 1, 30, s);
    end

    // R4 single-packet transmit
    cfg(1'b0, 1'b0, 1'b1);
    foreach (mpss[k]) begin
      mps_i = 9'(mpss[k]);
      clear();
      if (mpss[k] > 1) begin
        wr(mpss[k] - 1);
        chk_state("R4 below mps", 0, mpss[k] - 1, 0);
      end
      wr(1);
      chk_state("R4 at mps", 1, mpss[k], 0);
      wr(2);
      chk_state("R11 wr ignored", 1, mpss[k], 0);
    end
    mps_i = 9'd64;
    for (int k = 0; k < 6; k += 5) begin
      clear();
      wr(k);
      bval();
      chk_state("R4 bval short", 1, k, 0);
    end

    // R10 clear vs write in same cycle
    clear();
    wr(5);
    @(negedge clk_i);
    clr_i = 1'b1; sw_wr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; sw_wr_i = 1'b0;
    chk_state("R10 clear beats wr", 0, 0, 0);

    // R8 continuous transmit
    cfg(1'b1, 1'b0, 1'b1);
    clear();
    wr(255);
    chk_state("R8 below side", 0, 255, 0);
    wr(1);
    chk_state("R8 side full", 1, 256, 0);
    clear();
    bval();
    chk_state("R8 bval zero", 1, 0, 0);
    clear();
    wr(10);
    bval();
    chk_state("R8 bval partial", 1, 10, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule